// File: doc/BRIEF.md
# Register-Mapped 32-bit Adder with AXI4-Lite Slave Port

This block is an AXI4-Lite slave that wraps a 32-bit adder in a small register file. A host loads two operands through ordinary register writes, then launches the addition by writing a 1 to the launch bit of the control/status word. The block computes the 32-bit sum and the carry-out and places them in two read-only result registers. It then raises a done flag in the control/status word.

The done flag stays high until the host has read both result registers, in either order. Software can therefore poll a single bit and knows that fresh results are waiting. One five-state bus controller serves both channels, one transaction at a time. It accepts a write address and write data that arrive together or in separate cycles. Accesses to addresses outside the map, and accesses with a misaligned address, receive an error response and never stall the bus.

Top module: `axil_sum_unit`

## Requirements
- R1: After reset, every register (operand A at 0x00, operand B at 0x04, sum at 0x08, carry at 0x0C, control/status at 0x10) reads as zero, and BVALID and RVALID are low.
- R2: Operand A (0x00) and operand B (0x04) are read/write. A write changes only the bytes whose WSTRB bit is set, and a later read returns the stored value.
- R3: Writing the control/status word (0x10) with bit 0 set launches an addition. By the time the write response has been accepted, the sum is at 0x08, the carry is in bit 0 of 0x0C, the done bit (bit 1 of 0x10) reads 1, and the launch bit (bit 0 of 0x10) reads 0 again. A write to 0x10 with bit 0 clear launches nothing.
- R4: Any overflow beyond 32 bits sets the carry to 1. For example, 0xFFFFFFFF + 0xFFFFFFFF gives a sum of 0xFFFFFFFE with carry 1.
- R5: After an addition, the done bit stays set while only one of the two result registers has been read, even if that register is read repeatedly. It clears once both have been read, in either order.
- R6: Writes to the sum (0x08) or carry (0x0C) registers get an OKAY response (BRESP=0) and leave both registers unchanged.
- R7: A write to an address above 0x10 or to an address that is not word-aligned gets SLVERR (BRESP=2) and changes no register. A read of such an address returns RDATA=0 with RRESP=2. Later accesses work normally.
- R8: Write address and write data may arrive in the same cycle or in different cycles, in either order. BVALID rises only after both have been accepted.
- R9: If a write address, write data and a read address are all presented to an idle slave in the same cycle, the write is accepted first (ARREADY stays low). The read is served after the write response and returns data that already reflects the write.
- R10: Once raised, BVALID and BRESP, or RVALID, RDATA and RRESP, hold steady until the matching ready input is seen high.
- R11: A reset asserted while an addition is in flight aborts it. All registers read zero afterwards, and no response is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (0 OKAY, 2 SLVERR) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (0 OKAY, 2 SLVERR) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
Two functions can land on the same clock edge: a write arriving on both write channels, and a read request competing for the single bus controller. The bench provokes this by raising AWVALID, WVALID and ARVALID on the same edge while the slave is idle. It judges the outcome in three steps. ARREADY must stay low while the write is accepted. No RVALID may appear before the write response completes. The read, targeting the register just written, must return the new value. A second overlap, between the launch of an addition and the results it produces, is checked by reading the control/status word on the first cycle after the write response.

// File: rtl/axil_sum_pkg.sv
package axil_sum_pkg;

  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE_WAIT,
    ST_WRITE,
    ST_WRITE_RESP,
    ST_READ
  } bus_state_e;

  typedef enum logic [2:0] {
    SEL_OPA,
    SEL_OPB,
    SEL_SUM,
    SEL_CARRY,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // Map a byte address to a register; misaligned or unmapped gives SEL_NONE.
  function automatic reg_sel_e decode_addr(input logic [31:0] addr);
    reg_sel_e sel;
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else begin
      case (addr[31:2])
        30'd0:   sel = SEL_OPA;
        30'd1:   sel = SEL_OPB;
        30'd2:   sel = SEL_SUM;
        30'd3:   sel = SEL_CARRY;
        30'd4:   sel = SEL_CTRL;
        default: sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

  // Full-width sum: bit DATA_W is the carry-out.
  function automatic logic [DATA_W:0] wide_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Merge new bytes into an old word under byte enables.
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [STRB_W-1:0] en);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < STRB_W; i++) begin
      if (en[i]) res[8*i +: 8] = new_w[8*i +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/axil_bus_fsm.sv
module axil_bus_fsm
  import axil_sum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  // register-side interface
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  input  logic              wr_err,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err
);

  bus_state_e        state_q, state_d;
  logic              aw_have_q, w_have_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;

  logic aw_hs, w_hs, ar_hs;
  logic aw_ok, w_ok;

  assign awready = (state_q == ST_IDLE) || (state_q == ST_WRITE_WAIT && !aw_have_q);
  assign wready  = (state_q == ST_IDLE) || (state_q == ST_WRITE_WAIT && !w_have_q);
  // Write channels win over a concurrent read in idle.
  assign arready = (state_q == ST_IDLE) && !awvalid && !wvalid;

  assign aw_hs = awvalid && awready;
  assign w_hs  = wvalid && wready;
  assign ar_hs = arvalid && arready;
  assign aw_ok = aw_have_q || aw_hs;
  assign w_ok  = w_have_q || w_hs;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (aw_hs && w_hs)      state_d = ST_WRITE;
        else if (aw_hs || w_hs) state_d = ST_WRITE_WAIT;
        else if (ar_hs)         state_d = ST_READ;
      end
      ST_WRITE_WAIT: if (aw_ok && w_ok) state_d = ST_WRITE;
      ST_WRITE:      state_d = ST_WRITE_RESP;
      ST_WRITE_RESP: if (bready) state_d = ST_IDLE;
      ST_READ:       if (rready) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      aw_have_q <= 1'b0;
      w_have_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
      bresp_q   <= RESP_OKAY;
      rresp_q   <= RESP_OKAY;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (aw_hs) begin
        addr_q    <= awaddr;
        aw_have_q <= 1'b1;
      end
      if (w_hs) begin
        data_q   <= wdata;
        strb_q   <= wstrb;
        w_have_q <= 1'b1;
      end
      if (state_q == ST_WRITE) begin
        aw_have_q <= 1'b0;
        w_have_q  <= 1'b0;
        bresp_q   <= wr_err ? RESP_SLVERR : RESP_OKAY;
      end
      if (ar_hs) begin
        rdata_q <= rd_data;
        rresp_q <= rd_err ? RESP_SLVERR : RESP_OKAY;
      end
    end
  end

  assign wr_en   = (state_q == ST_WRITE);
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign wr_strb = strb_q;
  assign rd_en   = ar_hs;
  assign rd_addr = araddr;

  assign bvalid = (state_q == ST_WRITE_RESP);
  assign bresp  = bresp_q;
  assign rvalid = (state_q == ST_READ);
  assign rdata  = rdata_q;
  assign rresp  = rresp_q;

  p_write_then_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |=> bvalid);
  p_wait_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE_WAIT) |-> !bvalid && !rvalid);
  p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid && $stable(bresp));
  p_rvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> rvalid && $stable(rdata) && $stable(rresp));
  p_write_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && awvalid && wvalid && arvalid) |=> (state_q == ST_WRITE));
  p_one_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bvalid, rvalid}) <= 1);

endmodule

// File: rtl/axil_reg_bank.sv
module axil_reg_bank
  import axil_sum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  input  logic [DATA_W-1:0] sum_val,
  input  logic              carry_val,
  input  logic              done_val,
  input  logic              launch_val,
  output logic              launch_evt,
  output logic              rd_sum_evt,
  output logic              rd_carry_evt,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);

  localparam int NUM_OPS = 2;

  reg_sel_e wr_sel, rd_sel;
  logic [DATA_W-1:0] ops [NUM_OPS];

  assign wr_sel = decode_addr(32'(wr_addr));
  assign rd_sel = decode_addr(32'(rd_addr));
  assign wr_err = (wr_sel == SEL_NONE);
  assign rd_err = (rd_sel == SEL_NONE);

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
    localparam reg_sel_e MY_SEL = (gi == 0) ? SEL_OPA : SEL_OPB;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_sel == MY_SEL) q <= merge_bytes(q, wr_data, wr_strb);
    end
    assign ops[gi] = q;
  end

  assign op_a = ops[0];
  assign op_b = ops[1];

  assign launch_evt   = wr_en && (wr_sel == SEL_CTRL) && wr_data[0];
  assign rd_sum_evt   = rd_en && (rd_sel == SEL_SUM);
  assign rd_carry_evt = rd_en && (rd_sel == SEL_CARRY);

  always_comb begin
    unique case (rd_sel)
      SEL_OPA:   rd_data = op_a;
      SEL_OPB:   rd_data = op_b;
      SEL_SUM:   rd_data = sum_val;
      SEL_CARRY: rd_data = {{(DATA_W-1){1'b0}}, carry_val};
      SEL_CTRL:  rd_data = {{(DATA_W-2){1'b0}}, done_val, launch_val};
      default:   rd_data = '0;
    endcase
  end

  p_bad_write_keeps_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err) |=> $stable(op_a) && $stable(op_b));
  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_err) |-> (rd_data == '0));

endmodule

// File: rtl/adder_core.sv
module adder_core
  import axil_sum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_evt,
  input  logic              rd_sum_evt,
  input  logic              rd_carry_evt,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] sum_q,
  output logic              carry_q,
  output logic              done_q,
  output logic              launch_q
);

  logic seen_sum_q, seen_carry_q;
  logic seen_sum_d, seen_carry_d;
  logic [DATA_W:0] full_sum;

  assign full_sum     = wide_add(op_a, op_b);
  assign seen_sum_d   = seen_sum_q || rd_sum_evt;
  assign seen_carry_d = seen_carry_q || rd_carry_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q        <= '0;
      carry_q      <= 1'b0;
      done_q       <= 1'b0;
      launch_q     <= 1'b0;
      seen_sum_q   <= 1'b0;
      seen_carry_q <= 1'b0;
    end else if (launch_evt) begin
      launch_q     <= 1'b1;
      done_q       <= 1'b0;
      seen_sum_q   <= 1'b0;
      seen_carry_q <= 1'b0;
    end else if (launch_q) begin
      {carry_q, sum_q} <= full_sum;
      done_q           <= 1'b1;
      launch_q         <= 1'b0;
    end else if (done_q) begin
      if (seen_sum_d && seen_carry_d) begin
        done_q       <= 1'b0;
        seen_sum_q   <= 1'b0;
        seen_carry_q <= 1'b0;
      end else begin
        seen_sum_q   <= seen_sum_d;
        seen_carry_q <= seen_carry_d;
      end
    end
  end

  p_launch_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |=> !launch_q && done_q);
  p_sum_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |=> (sum_q == $past(op_a + op_b)) && (carry_q == ($past(op_a) > ~$past(op_b))));
  p_done_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(rd_sum_evt || rd_carry_evt || launch_evt));
  p_results_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(launch_q) && !launch_q |-> $stable(sum_q) && $stable(carry_q));

endmodule

// File: rtl/axil_sum_unit.sv
module axil_sum_unit
  import axil_sum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);

  logic              wr_en, wr_err, rd_en, rd_err;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  logic              launch_evt, rd_sum_evt, rd_carry_evt;
  logic [DATA_W-1:0] op_a, op_b, sum_q;
  logic              carry_q, done_q, launch_q;

  axil_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(aclk), .rst_n(aresetn),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .wr_err(wr_err), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_err(rd_err)
  );

  axil_reg_bank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(aclk), .rst_n(aresetn),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .wr_err(wr_err), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_err(rd_err), .sum_val(sum_q), .carry_val(carry_q), .done_val(done_q),
    .launch_val(launch_q), .launch_evt(launch_evt), .rd_sum_evt(rd_sum_evt),
    .rd_carry_evt(rd_carry_evt), .op_a(op_a), .op_b(op_b)
  );

  adder_core u_core (
    .clk(aclk), .rst_n(aresetn),
    .launch_evt(launch_evt), .rd_sum_evt(rd_sum_evt), .rd_carry_evt(rd_carry_evt),
    .op_a(op_a), .op_b(op_b), .sum_q(sum_q), .carry_q(carry_q),
    .done_q(done_q), .launch_q(launch_q)
  );

endmodule

// File: tb/sim_axil_sum_unit.sv
module sim_axil_sum_unit;

  logic        clk = 1'b0;
  logic        aresetn = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  axil_sum_unit #(.ADDR_W(8)) u0 (
    .aclk(clk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [31:0] data,
                          input logic [3:0] strb, input int aw_dly, input int w_dly,
                          input int b_dly, output logic [1:0] resp);
    bit aw_done = 0;
    bit w_done = 0;
    int n = 0;
    int early = 0;
    int slip = 0;
    while (!(aw_done && w_done)) begin
      @(negedge clk);
      awaddr  = addr;
      wdata   = data;
      wstrb   = strb;
      awvalid = !aw_done && (n >= aw_dly);
      wvalid  = !w_done && (n >= w_dly);
      if (bvalid) early++;
      #1;
      if (awvalid && awready) aw_done = 1;
      if (wvalid && wready) w_done = 1;
      n++;
    end
    @(negedge clk);
    awvalid = 0;
    wvalid  = 0;
    while (!bvalid) @(negedge clk);
    resp = bresp;
    for (int k = 0; k < b_dly; k++) begin
      @(negedge clk);
      if (!bvalid || bresp !== resp) slip++;
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    if (aw_dly != w_dly) check("R8 no early BVALID", 32'(early), 0);
    if (b_dly > 0) check("R10 BVALID held", 32'(slip), 0);
  endtask

  task automatic do_read(input logic [7:0] addr, input int r_dly,
                         output logic [31:0] data, output logic [1:0] resp);
    bit done = 0;
    int slip = 0;
    while (!done) begin
      @(negedge clk);
      araddr  = addr;
      arvalid = 1;
      #1;
      if (arready) done = 1;
    end
    @(negedge clk);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    data = rdata;
    resp = rresp;
    for (int k = 0; k < r_dly; k++) begin
      @(negedge clk);
      if (!rvalid || rdata !== data || rresp !== resp) slip++;
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
    if (r_dly > 0) check("R10 RVALID held", 32'(slip), 0);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    logic [1:0] r;
    do_write(addr, data, 4'hF, 0, 0, 0, r);
  endtask

  task automatic rd_expect(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] d;
    logic [1:0] r;
    do_read(addr, 0, d, r);
    check(req, d, exp);
  endtask

  task automatic apply_reset();
    aresetn = 0;
    repeat (3) @(negedge clk);
    aresetn = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 bvalid", 32'(bvalid), 0);
    check("R1 rvalid", 32'(rvalid), 0);
    for (int a = 0; a <= 16; a += 4) rd_expect("R1 reg zero", 8'(a), 0);
  endtask

  task automatic t_operands();
    logic [1:0] r;
    wr(8'h00, 32'h1234_5678);
    wr(8'h04, 32'h9ABC_DEF0);
    rd_expect("R2 opA readback", 8'h00, 32'h1234_5678);
    rd_expect("R2 opB readback", 8'h04, 32'h9ABC_DEF0);
    do_write(8'h00, 32'hFFFF_AAAA, 4'b0011, 0, 0, 0, r);
    rd_expect("R2 strobe merge", 8'h00, 32'h1234_AAAA);
  endtask

  task automatic add_case(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] ref_v;
    ref_v = 33'(a) + 33'(b);
    wr(8'h00, a);
    wr(8'h04, b);
    wr(8'h10, 32'h1);
    rd_expect("R3 done set, launch clear", 8'h10, 32'h2);
    rd_expect("R4 sum", 8'h08, ref_v[31:0]);
    rd_expect("R4 carry", 8'h0C, {31'b0, ref_v[32]});
  endtask

  task automatic t_add();
    add_case(32'd5, 32'd7);
    add_case(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    add_case(32'h8000_0000, 32'h8000_0000);
    rd_expect("R4 literal max sum", 8'h08, 32'h0000_0000);
    add_case(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(8'h00, 32'd1);
    wr(8'h10, 32'h0);
    rd_expect("R3 no launch on bit0=0", 8'h10, 32'h0);
    rd_expect("R3 sum kept", 8'h08, 32'hFFFF_FFFE);
  endtask

  task automatic t_done();
    wr(8'h00, 32'd10);
    wr(8'h04, 32'd20);
    wr(8'h10, 32'h1);
    rd_expect("R5 sum", 8'h08, 32'd30);
    rd_expect("R5 done after sum only", 8'h10, 32'h2);
    rd_expect("R5 sum again", 8'h08, 32'd30);
    rd_expect("R5 done after sum twice", 8'h10, 32'h2);
    rd_expect("R5 carry", 8'h0C, 32'h0);
    rd_expect("R5 done cleared", 8'h10, 32'h0);
    wr(8'h10, 32'h1);
    rd_expect("R5 carry first", 8'h0C, 32'h0);
    rd_expect("R5 done after carry only", 8'h10, 32'h2);
    rd_expect("R5 sum second", 8'h08, 32'd30);
    rd_expect("R5 done cleared reverse", 8'h10, 32'h0);
  endtask

  task automatic t_readonly();
    logic [1:0] r;
    do_write(8'h08, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, r);
    check("R6 sum write OKAY", 32'(r), 0);
    do_write(8'h0C, 32'h0, 4'hF, 0, 0, 0, r);
    check("R6 carry write OKAY", 32'(r), 0);
    rd_expect("R6 sum unchanged", 8'h08, 32'd30);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'd2);
    wr(8'h10, 32'h1);
    do_write(8'h0C, 32'h0, 4'hF, 0, 0, 0, r);
    rd_expect("R6 carry unchanged", 8'h0C, 32'h1);
  endtask

  task automatic t_errors();
    logic [1:0] r;
    logic [31:0] d;
    wr(8'h00, 32'h0000_00A5);
    do_write(8'h14, 32'h1, 4'hF, 0, 0, 0, r);
    check("R7 out-of-range write SLVERR", 32'(r), 2);
    do_write(8'h02, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, r);
    check("R7 misaligned write SLVERR", 32'(r), 2);
    rd_expect("R7 opA untouched", 8'h00, 32'h0000_00A5);
    do_read(8'h20, 0, d, r);
    check("R7 bad read data", d, 0);
    check("R7 bad read SLVERR", 32'(r), 2);
    do_read(8'h05, 0, d, r);
    check("R7 misaligned read SLVERR", 32'(r), 2);
    do_read(8'h00, 0, d, r);
    check("R7 recovers resp", 32'(r), 0);
    check("R7 recovers data", d, 32'h0000_00A5);
  endtask

  task automatic t_split();
    logic [1:0] r;
    do_write(8'h00, 32'h0BAD_CAFE, 4'hF, 0, 3, 0, r);
    rd_expect("R8 addr first", 8'h00, 32'h0BAD_CAFE);
    do_write(8'h04, 32'h1357_9BDF, 4'hF, 2, 0, 0, r);
    rd_expect("R8 data first", 8'h04, 32'h1357_9BDF);
  endtask

  task automatic t_backpressure();
    logic [1:0] r;
    logic [31:0] d;
    do_write(8'h14, 32'h0, 4'hF, 0, 0, 4, r);
    check("R10 held resp value", 32'(r), 2);
    do_read(8'h04, 5, d, r);
    check("R10 held read data", d, 32'h1357_9BDF);
  endtask

  task automatic t_priority();
    int rv_early = 0;
    @(negedge clk);
    awaddr = 8'h00; wdata = 32'h0000_0055; wstrb = 4'hF; araddr = 8'h00;
    awvalid = 1; wvalid = 1; arvalid = 1;
    #1;
    check("R9 write accepted", {30'b0, awready, wready}, 32'h3);
    check("R9 read held off", 32'(arready), 0);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    while (!bvalid) begin
      if (rvalid) rv_early++;
      @(negedge clk);
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    check("R9 no read before write resp", 32'(rv_early), 0);
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    while (!rvalid) @(negedge clk);
    check("R9 read sees write", rdata, 32'h0000_0055);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic t_reset_mid();
    wr(8'h00, 32'd3);
    wr(8'h04, 32'd4);
    @(negedge clk);
    awaddr = 8'h10; wdata = 32'h1; wstrb = 4'hF;
    awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    aresetn = 0;
    repeat (2) @(negedge clk);
    aresetn = 1;
    @(negedge clk);
    check("R11 no pending bvalid", 32'(bvalid), 0);
    rd_expect("R11 ctrl zero", 8'h10, 0);
    rd_expect("R11 sum zero", 8'h08, 0);
    rd_expect("R11 opA zero", 8'h00, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    apply_reset();
    t_reset();
    t_operands();
    t_add();
    t_done();
    t_readonly();
    t_errors();
    t_split();
    t_backpressure();
    t_priority();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule